// File: doc/BRIEF.md
# Double-Buffered PCM Sample Port

This block moves 16-bit PCM samples between the peripheral bus and a converter core that works at a fixed sample rate. A free-running divider counts system clocks up to a programmable terminal value and emits one sample strobe per period. With a 125 µs setting, that gives an 8 kHz rate. On each strobe the core's working input register takes the value that the bus last wrote into the input holding register. In the same cycle, the output holding register that the bus reads takes the sample the core presents. Because of this double buffering, software has a full sample period to supply the next input and collect the last output.

Each strobe also raises a sample event. The event sets a status flag that clears when status is read. The same event feeds a level interrupt and two DMA requests, one for input and one for output, each behind its own enable. When the interrupt and DMA enables are both set, both fire on the same strobe. A DMA mover works indirectly, so it reads or writes the sample through the same bus port. The input request drops on a bus write and the output request drops on a bus read. If no new input was written during a period, the core reuses the held value and an overrun flag is set. A freeze input keeps the output holding register from updating and stops status reads from clearing the flags.

Top module: `pcm_dbuf_port`

## Requirements
- R1: During and right after reset, `bus_rd_data`, `core_in_sample`, `evt_flag`, `ovr_flag`, `irq`, `dma_in_req` and `dma_out_req` are all zero.
- R2: `core_tick` is high for one cycle out of every `tick_limit`+1 cycles. The first strobe is high during the cycle that follows the `tick_limit`-th rising edge after reset is released.
- R3: At the edge that ends a strobe cycle, `core_in_sample` takes the held input value. A bus write in the strobe cycle itself updates the holding register only, and is passed on at the next strobe. `core_in_sample` does not change at any other edge.
- R4: At a strobe edge with `freeze` low, `bus_rd_data` takes `core_out_sample`. It does not change at any other edge.
- R5: At a strobe edge with `freeze` high, `bus_rd_data` keeps its value.
- R6: `evt_flag` is set by every strobe. A `stat_rd_en` pulse with `freeze` low clears both `evt_flag` and `ovr_flag`. When a flag is set and cleared in the same cycle, the set wins.
- R7: While `freeze` is high, `stat_rd_en` leaves `evt_flag` and `ovr_flag` unchanged.
- R8: `irq` equals `evt_flag` when `irq_en` is high and is low when `irq_en` is low.
- R9: `dma_in_req` is set by a strobe when `dma_in_en` is high and is cleared by `bus_wr_en`.
- R10: `dma_out_req` is set by a strobe when `dma_out_en` is high and is cleared by `bus_rd_en`.
- R11: A strobe with no bus write since the previous strobe sets `ovr_flag`. In that case `core_in_sample` repeats its previous value.
- R12: With `irq_en`, `dma_in_en` and `dma_out_en` all high, one strobe raises `irq`, `dma_in_req` and `dma_out_req` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_limit | input | CNT_W (16) | Terminal count of the sample divider (period = value + 1 clocks) |
| freeze | input | 1 | Blocks output holding updates and clear-on-read |
| irq_en | input | 1 | Interrupt enable for the sample event |
| dma_in_en | input | 1 | Input DMA request enable |
| dma_out_en | input | 1 | Output DMA request enable |
| bus_wr_en | input | 1 | Bus write strobe to the input holding register |
| bus_wr_data | input | SAMPLE_W (16) | Bus write data |
| bus_rd_en | input | 1 | Bus read strobe of the output holding register |
| bus_rd_data | output | SAMPLE_W (16) | Output holding register |
| stat_rd_en | input | 1 | Status read strobe (clear-on-read) |
| evt_flag | output | 1 | Sample event status flag |
| ovr_flag | output | 1 | Input overrun status flag |
| irq | output | 1 | Interrupt request |
| dma_in_req | output | 1 | DMA request for the next input sample |
| dma_out_req | output | 1 | DMA request to collect the output sample |
| core_tick | output | 1 | Sample strobe to the converter core |
| core_in_sample | output | SAMPLE_W (16) | Working input sample presented to the core |
| core_out_sample | input | SAMPLE_W (16) | Sample produced by the core |

## Verification
Every cycle, the assertions check several properties. Both sample registers may change only on a strobe edge, and a frozen strobe must leave the output holding register alone. A frozen status read must never drop the event flag. An enabled strobe must always leave the matching DMA request raised. A strobe must never repeat in the next cycle when the terminal value is non-zero. Only the bench's scenarios can confirm the data that actually moves through the port: which write reaches the core when it coincides with a strobe, that overrun repeats the old sample, the exact divider period, the set-over-clear priority on a status read, and the drop of each DMA request on its own bus access.

// File: rtl/pcm_dbuf_pkg.sv
package pcm_dbuf_pkg;

  // Sticky status bit: a set always wins, a clear works only when not frozen.
  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr, input logic frz);
    return set | (q & ~(clr & ~frz));
  endfunction

  // Request bit: raised by its event, dropped by its servicing access.
  function automatic logic req_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // Divider: the strobe fires once the count reaches the terminal value.
  function automatic logic at_terminal(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/pcm_tick_gen.sv
module pcm_tick_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tick_limit,
  output logic             tick
);
  import pcm_dbuf_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign tick = at_terminal(32'(cnt_q), 32'(tick_limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_limit != '0) |=> (!tick || tick_limit == '0));

endmodule

// File: rtl/pcm_in_path.sv
module pcm_in_path #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bus_wr_en,
  input  logic [SAMPLE_W-1:0] bus_wr_data,
  output logic [SAMPLE_W-1:0] core_in_sample,
  output logic                ovr_evt
);
  logic [SAMPLE_W-1:0] hold_q;
  logic [SAMPLE_W-1:0] work_q;
  logic                fresh_q;

  // Overrun: the strobe finds no write since the previous strobe.
  assign ovr_evt        = tick & ~fresh_q;
  assign core_in_sample = work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      work_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (bus_wr_en) hold_q <= bus_wr_data;
      if (tick)      work_q <= hold_q;
      // A write in the strobe cycle counts toward the next period.
      if (bus_wr_en)  fresh_q <= 1'b1;
      else if (tick)  fresh_q <= 1'b0;
    end
  end

  // R3
  in_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(core_in_sample));

  // R11
  in_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(core_in_sample));

endmodule

// File: rtl/pcm_out_path.sv
module pcm_out_path #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                freeze,
  input  logic [SAMPLE_W-1:0] core_out_sample,
  output logic [SAMPLE_W-1:0] bus_rd_data
);
  logic [SAMPLE_W-1:0] hold_q;
  logic                load;

  assign load        = tick & ~freeze;
  assign bus_rd_data = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= core_out_sample;
  end

  // R4
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bus_rd_data));

  // R5
  out_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && freeze) |=> $stable(bus_rd_data));

endmodule

// File: rtl/pcm_evt_ctl.sv
module pcm_evt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ovr_evt,
  input  logic freeze,
  input  logic stat_rd_en,
  input  logic irq_en,
  input  logic dma_in_en,
  input  logic dma_out_en,
  input  logic bus_wr_en,
  input  logic bus_rd_en,
  output logic evt_flag,
  output logic ovr_flag,
  output logic irq,
  output logic dma_in_req,
  output logic dma_out_req
);
  import pcm_dbuf_pkg::*;

  localparam int NREQ = 2;  // channel 0: input, channel 1: output

  logic            evt_q, ovr_q;
  logic [NREQ-1:0] req_set, req_clr, req_q;

  assign req_set = {tick & dma_out_en, tick & dma_in_en};
  assign req_clr = {bus_rd_en, bus_wr_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      evt_q <= sticky_next(evt_q, tick, stat_rd_en, freeze);
      ovr_q <= sticky_next(ovr_q, ovr_evt, stat_rd_en, freeze);
    end
  end

  for (genvar ch = 0; ch < NREQ; ch++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[ch] <= 1'b0;
      else        req_q[ch] <= req_next(req_q[ch], req_set[ch], req_clr[ch]);
    end
  end

  assign evt_flag    = evt_q;
  assign ovr_flag    = ovr_q;
  assign irq         = evt_q & irq_en;
  assign dma_in_req  = req_q[0];
  assign dma_out_req = req_q[1];

  // R6
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> evt_flag);

  // R7
  evt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !$fell(evt_flag));

  // R9
  dma_in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dma_in_en) |=> dma_in_req);

  // R10
  dma_out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dma_out_en) |=> dma_out_req);

endmodule

// File: rtl/pcm_dbuf_port.sv
module pcm_dbuf_port #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    tick_limit,
  input  logic                freeze,
  input  logic                irq_en,
  input  logic                dma_in_en,
  input  logic                dma_out_en,
  input  logic                bus_wr_en,
  input  logic [SAMPLE_W-1:0] bus_wr_data,
  input  logic                bus_rd_en,
  output logic [SAMPLE_W-1:0] bus_rd_data,
  input  logic                stat_rd_en,
  output logic                evt_flag,
  output logic                ovr_flag,
  output logic                irq,
  output logic                dma_in_req,
  output logic                dma_out_req,
  output logic                core_tick,
  output logic [SAMPLE_W-1:0] core_in_sample,
  input  logic [SAMPLE_W-1:0] core_out_sample
);
  // Named internal events shared by the sub-blocks and their assertions.
  logic sample_tick;
  logic overrun_evt;

  assign core_tick = sample_tick;

  pcm_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_limit(tick_limit), .tick(sample_tick)
  );

  pcm_in_path #(.SAMPLE_W(SAMPLE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
    .core_in_sample(core_in_sample), .ovr_evt(overrun_evt)
  );

  pcm_out_path #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .freeze(freeze),
    .core_out_sample(core_out_sample), .bus_rd_data(bus_rd_data)
  );

  pcm_evt_ctl u_evt (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .ovr_evt(overrun_evt),
    .freeze(freeze), .stat_rd_en(stat_rd_en), .irq_en(irq_en),
    .dma_in_en(dma_in_en), .dma_out_en(dma_out_en),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .evt_flag(evt_flag), .ovr_flag(ovr_flag), .irq(irq),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
  );

  // R12
  joint_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && irq_en && dma_in_en && dma_out_en) |=>
      (evt_flag && dma_in_req && dma_out_req));

endmodule

// File: tb/pcm_dbuf_port_tb.sv
module pcm_dbuf_port_tb;
  localparam int W   = 16;
  localparam int CW  = 16;
  localparam int LIM = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] tick_limit = CW'(LIM);
  logic          freeze = 0, irq_en = 0, dma_in_en = 0, dma_out_en = 0;
  logic          bus_wr_en = 0, bus_rd_en = 0, stat_rd_en = 0;
  logic [W-1:0]  bus_wr_data = '0, core_out_sample = '0;
  logic [W-1:0]  bus_rd_data, core_in_sample;
  logic          evt_flag, ovr_flag, irq, dma_in_req, dma_out_req, core_tick;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pcm_dbuf_port #(.SAMPLE_W(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_limit(tick_limit), .freeze(freeze),
    .irq_en(irq_en), .dma_in_en(dma_in_en), .dma_out_en(dma_out_en),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .stat_rd_en(stat_rd_en), .evt_flag(evt_flag),
    .ovr_flag(ovr_flag), .irq(irq), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .core_tick(core_tick),
    .core_in_sample(core_in_sample), .core_out_sample(core_out_sample)
  );

  typedef struct packed {
    logic         wr;
    logic [W-1:0] wv;
    logic [W-1:0] cv;
    logic         frz;
    logic [W-1:0] exp_in;
    logic [W-1:0] exp_out;
    logic         exp_ovr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1234, 16'hA001, 1'b0, 16'h1234, 16'hA001, 1'b0},
    '{1'b1, 16'h8001, 16'h7FFF, 1'b0, 16'h8001, 16'h7FFF, 1'b0},
    '{1'b0, 16'h0000, 16'h5555, 1'b0, 16'h8001, 16'h5555, 1'b1},
    '{1'b1, 16'h0F0F, 16'hBEEF, 1'b1, 16'h0F0F, 16'h5555, 1'b0},
    '{1'b1, 16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 16'h0000, 1'b0},
    '{1'b0, 16'h0000, 16'h1111, 1'b1, 16'hFFFF, 16'h0000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Stop at the negedge just before a strobe edge.
  task automatic wait_tick_pre();
    do @(negedge clk); while (!core_tick);
  endtask

  // Stop at the negedge just after a strobe edge.
  task automatic next_tick();
    wait_tick_pre();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [W-1:0] v);
    bus_wr_en = 1'b1; bus_wr_data = v;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd_en = 1'b1;
    @(negedge clk);
    stat_rd_en = 1'b0;
  endtask

  task automatic pulse_rd();
    bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL R2: watchdog expired, actual no finish expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rd_data", 32'(bus_rd_data), 0);
    chk("R1 core_in", 32'(core_in_sample), 0);
    chk("R1 flags", {evt_flag, ovr_flag, irq}, 0);
    chk("R1 dma", {dma_in_req, dma_out_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data after release", 32'(bus_rd_data), 0);

    // R2: first strobe and period
    cnt = 1;
    while (!core_tick) begin @(negedge clk); cnt++; end
    chk("R2 first strobe", cnt, LIM);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!core_tick);
    chk("R2 period", cnt, LIM + 1);
    @(negedge clk);

    // Vector table: R3 R4 R5 R11
    for (int i = 0; i < NV; i++) begin
      freeze = 1'b0;
      pulse_stat();
      if (VECS[i].wr) bus_write(VECS[i].wv);
      core_out_sample = VECS[i].cv;
      freeze = VECS[i].frz;
      next_tick();
      chk($sformatf("R3 vec%0d core_in", i), 32'(core_in_sample), 32'(VECS[i].exp_in));
      chk($sformatf("R4/R5 vec%0d rd_data", i), 32'(bus_rd_data), 32'(VECS[i].exp_out));
      chk($sformatf("R11 vec%0d ovr", i), 32'(ovr_flag), 32'(VECS[i].exp_ovr));
    end
    freeze = 1'b0;

    // R6: set wins over a coinciding status read
    pulse_stat();
    wait_tick_pre();
    stat_rd_en = 1'b1;
    @(negedge clk);
    stat_rd_en = 1'b0;
    chk("R6 set beats clear", 32'(evt_flag), 1);

    // R7: frozen status read keeps flags, unfrozen read clears them
    freeze = 1'b1;
    pulse_stat();
    chk("R7 frozen read keeps evt", 32'(evt_flag), 1);
    freeze = 1'b0;
    pulse_stat();
    chk("R6 read clears evt", 32'(evt_flag), 0);

    // R3: write in the strobe cycle waits for the next strobe
    bus_write(16'h2222);
    wait_tick_pre();
    bus_wr_en = 1'b1; bus_wr_data = 16'hCAFE;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk("R3 coincident write not passed", 32'(core_in_sample), 32'h2222);
    pulse_stat();
    next_tick();
    chk("R3 coincident write passed next", 32'(core_in_sample), 32'hCAFE);
    chk("R11 coincident write counts", 32'(ovr_flag), 0);

    // R12 R9 R10 R8: shared event drives interrupt and both requests
    irq_en = 1'b1; dma_in_en = 1'b1; dma_out_en = 1'b1;
    pulse_stat();
    next_tick();
    chk("R12 joint irq", 32'(irq), 1);
    chk("R12 joint dma", {dma_in_req, dma_out_req}, 2'b11);
    bus_write(16'h0001);
    chk("R9 write drops in req", 32'(dma_in_req), 0);
    chk("R10 write leaves out req", 32'(dma_out_req), 1);
    pulse_rd();
    chk("R10 read drops out req", 32'(dma_out_req), 0);
    irq_en = 1'b0;
    #1;
    chk("R8 irq masked", {irq, evt_flag}, 2'b01);
    dma_in_en = 1'b0; dma_out_en = 1'b0;
    next_tick();
    chk("R9 no req when disabled", {dma_in_req, dma_out_req}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule